// File: doc/BRIEF.md
# CAN Receive Mailbox Allocator

This block takes each frame delivered by a CAN receiver core and places it in a bank of receive mailboxes. Every mailbox has three settings: a mode, an identifier, and an acceptance mask with an extended-frame selector. A frame goes to the lowest-numbered mailbox that is enabled for reception, is empty, and whose filter accepts the frame. Filled mailboxes keep their frame and show it on the outputs until the host re-arms them with a bitmask command.

A mailbox in overwrite mode can take a new frame while it is still full, but only when no empty mailbox accepts that frame. When this happens the mailbox marks that a frame was lost. A frame that finds no mailbox at all is dropped and sets a sticky overrun flag. The host reads each mailbox through a status word and through flat identifier and data buses. The host decides the order in which it reads the mailboxes.

Top module: `can_rx_mailbox`

## Requirements
- R1: When `rx_valid` is high, the frame is stored in the lowest-numbered mailbox that is enabled for reception, empty and accepting. The next cycle shows its identifier on `mb_rx_id`, its data on `mb_rx_data`, and the mailbox's bit set in `mb_ready` (bit m belongs to mailbox m).
- R2: Each mailbox has a 3-bit mode. Code 0 disables the mailbox. Code 1 is plain receive and code 2 is receive-with-overwrite. A mailbox with code 0, or with any code other than 1 or 2, never takes a frame.
- R3: A mailbox accepts a frame when `((rx_id ^ mb_id) & mb_mask) == 0` and `rx_ext` equals that mailbox's `mb_ext` bit. A zero mask therefore accepts every identifier of the selected kind. A standard identifier sits in bits 28:18 of the 29-bit identifier, and the lower bits are zero.
- R4: A full mailbox in mode 2 that accepts the frame is overwritten only when no empty mailbox accepts it. The lowest such mailbox is chosen, and its lost flag is set.
- R5: Each mailbox's 32-bit status word carries the length code in bits 19:16, the remote-frame flag in bit 20, ready in bit 23 and lost in bit 24. All other bits are zero.
- R6: Every bit set in `rearm` clears the ready and lost flags of that mailbox on the next cycle. The mailbox's contents are left unchanged.
- R7: A frame that no mailbox can take leaves every mailbox's flags unchanged. It sets `overrun`, which stays set until reset.
- R8: When a frame and a re-arm arrive in the same cycle, the frame is placed according to the state before the re-arm. A mailbox being re-armed in that cycle does not count as empty for that frame.
- R9: After reset, all ready flags, all lost flags and `overrun` are zero.
- R10: A frame fills at most one mailbox, and no mailbox becomes ready in a cycle without a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received frame is present this cycle |
| rx_id | input | 29 | Frame identifier (standard identifiers in bits 28:18) |
| rx_ext | input | 1 | Frame uses an extended identifier |
| rx_rtr | input | 1 | Frame is a remote frame |
| rx_dlc | input | 4 | Frame length code |
| rx_data | input | 64 | Frame payload |
| mb_mode | input | NUM_MB*3 | Mode of each mailbox, 3 bits per mailbox |
| mb_id | input | NUM_MB*29 | Filter identifier of each mailbox |
| mb_mask | input | NUM_MB*29 | Acceptance mask of each mailbox |
| mb_ext | input | NUM_MB | Extended-frame selector of each mailbox |
| rearm | input | NUM_MB | Re-arm command, one bit per mailbox |
| mb_ready | output | NUM_MB | Full flag of each mailbox |
| mb_status | output | NUM_MB*32 | Status word of each mailbox |
| mb_rx_id | output | NUM_MB*29 | Stored identifier of each mailbox |
| mb_rx_data | output | NUM_MB*64 | Stored payload of each mailbox |
| overrun | output | 1 | Sticky flag for a dropped frame |

## Verification
A wrong ready flag shows at the ports one cycle after the frame that set it. It shows as a wrong bit in `mb_ready`, or later as the next frame landing in the wrong mailbox. A corrupt priority pick puts a frame into a higher mailbox, so it appears in the wrong `mb_rx_id` slice at once. A wrong lost or overrun flag shows in the status word or on `overrun` in the cycle after the frame that overwrote or was dropped. The bench tracks the expected ready, lost and overrun values after every frame or re-arm, including a re-arm that arrives in the same cycle as a frame.

// File: rtl/can_rx_mailbox_pkg.sv
package can_rx_mailbox_pkg;

    localparam int CAN_ID_W   = 29;
    localparam int CAN_DATA_W = 64;
    localparam int MODE_W     = 3;
    localparam int STAT_W     = 32;

    typedef enum logic [MODE_W-1:0] {
        MB_OFF     = 3'd0,
        MB_RX      = 3'd1,
        MB_RX_OVWR = 3'd2
    } mb_mode_e;

    typedef struct packed {
        logic                  ready;
        logic                  lost;
        logic                  rtr;
        logic [3:0]            dlc;
        logic [CAN_ID_W-1:0]   id;
        logic [CAN_DATA_W-1:0] data;
    } mb_entry_t;

endpackage

// File: rtl/can_rx_accept.sv
module can_rx_accept
    import can_rx_mailbox_pkg::*;
#(
    parameter int NUM_MB = 8
) (
    input  logic [CAN_ID_W-1:0]        rx_id,
    input  logic                       rx_ext,
    input  logic [NUM_MB*MODE_W-1:0]   mb_mode,
    input  logic [NUM_MB*CAN_ID_W-1:0] mb_id,
    input  logic [NUM_MB*CAN_ID_W-1:0] mb_mask,
    input  logic [NUM_MB-1:0]          mb_ext,
    output logic [NUM_MB-1:0]          hit,
    output logic [NUM_MB-1:0]          ovwr
);

    for (genvar m = 0; m < NUM_MB; m++) begin : g_flt
        logic [MODE_W-1:0] mode;
        logic              id_ok;
        logic              rx_on;

        assign mode  = mb_mode[m*MODE_W +: MODE_W];
        assign id_ok = (((rx_id ^ mb_id[m*CAN_ID_W +: CAN_ID_W])
                         & mb_mask[m*CAN_ID_W +: CAN_ID_W]) == '0)
                       && (rx_ext == mb_ext[m]);
        assign rx_on = (mode == MB_RX) || (mode == MB_RX_OVWR);
        assign hit[m]  = id_ok && rx_on;
        assign ovwr[m] = (mode == MB_RX_OVWR);
    end

endmodule

// File: rtl/can_rx_lowest.sv
module can_rx_lowest #(
    parameter int NUM_MB = 8,
    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic [NUM_MB-1:0] req,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/can_rx_mailbox.sv
module can_rx_mailbox
    import can_rx_mailbox_pkg::*;
#(
    parameter int NUM_MB = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_valid,
    input  logic [CAN_ID_W-1:0]          rx_id,
    input  logic                         rx_ext,
    input  logic                         rx_rtr,
    input  logic [3:0]                   rx_dlc,
    input  logic [CAN_DATA_W-1:0]        rx_data,
    input  logic [NUM_MB*MODE_W-1:0]     mb_mode,
    input  logic [NUM_MB*CAN_ID_W-1:0]   mb_id,
    input  logic [NUM_MB*CAN_ID_W-1:0]   mb_mask,
    input  logic [NUM_MB-1:0]            mb_ext,
    input  logic [NUM_MB-1:0]            rearm,
    output logic [NUM_MB-1:0]            mb_ready,
    output logic [NUM_MB*STAT_W-1:0]     mb_status,
    output logic [NUM_MB*CAN_ID_W-1:0]   mb_rx_id,
    output logic [NUM_MB*CAN_DATA_W-1:0] mb_rx_data,
    output logic                         overrun
);

    localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1;

    typedef struct packed {
        mb_entry_t [NUM_MB-1:0] mb;
        logic                   ovr;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_MB-1:0] hit, ovwr, full;
    logic [NUM_MB-1:0] free_req, ovwr_req;
    logic              free_found, ovwr_found;
    logic [IDX_W-1:0]  free_idx, ovwr_idx;

    can_rx_accept #(.NUM_MB(NUM_MB)) u_accept (
        .rx_id   (rx_id),
        .rx_ext  (rx_ext),
        .mb_mode (mb_mode),
        .mb_id   (mb_id),
        .mb_mask (mb_mask),
        .mb_ext  (mb_ext),
        .hit     (hit),
        .ovwr    (ovwr)
    );

    for (genvar m = 0; m < NUM_MB; m++) begin : g_full
        assign full[m] = st_q.mb[m].ready;
    end

    assign free_req = hit & ~full;
    assign ovwr_req = hit & ovwr & full;

    can_rx_lowest #(.NUM_MB(NUM_MB)) u_pick_free (
        .req   (free_req),
        .found (free_found),
        .idx   (free_idx)
    );

    can_rx_lowest #(.NUM_MB(NUM_MB)) u_pick_ovwr (
        .req   (ovwr_req),
        .found (ovwr_found),
        .idx   (ovwr_idx)
    );

    always_comb begin
        st_d = st_q;
        // re-arm first, so a store in the same cycle wins on its mailbox
        for (int m = 0; m < NUM_MB; m++) begin
            if (rearm[m]) begin
                st_d.mb[m].ready = 1'b0;
                st_d.mb[m].lost  = 1'b0;
            end
        end
        if (rx_valid) begin
            if (free_found) begin
                st_d.mb[free_idx].ready = 1'b1;
                st_d.mb[free_idx].lost  = 1'b0;
                st_d.mb[free_idx].rtr   = rx_rtr;
                st_d.mb[free_idx].dlc   = rx_dlc;
                st_d.mb[free_idx].id    = rx_id;
                st_d.mb[free_idx].data  = rx_data;
            end else if (ovwr_found) begin
                st_d.mb[ovwr_idx].ready = 1'b1;
                st_d.mb[ovwr_idx].lost  = 1'b1;
                st_d.mb[ovwr_idx].rtr   = rx_rtr;
                st_d.mb[ovwr_idx].dlc   = rx_dlc;
                st_d.mb[ovwr_idx].id    = rx_id;
                st_d.mb[ovwr_idx].data  = rx_data;
            end else begin
                st_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar m = 0; m < NUM_MB; m++) begin : g_out
        assign mb_ready[m] = st_q.mb[m].ready;
        assign mb_status[m*STAT_W +: STAT_W] =
            {7'd0, st_q.mb[m].lost, st_q.mb[m].ready, 2'd0,
             st_q.mb[m].rtr, st_q.mb[m].dlc, 16'd0};
        assign mb_rx_id[m*CAN_ID_W +: CAN_ID_W]       = st_q.mb[m].id;
        assign mb_rx_data[m*CAN_DATA_W +: CAN_DATA_W] = st_q.mb[m].data;
    end

    assign overrun = st_q.ovr;

endmodule

// File: rtl/can_rx_mailbox_chk.sv
module can_rx_mailbox_chk #(
    parameter int NUM_MB = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rx_valid,
    input logic [NUM_MB-1:0]      rearm,
    input logic [NUM_MB-1:0]      mb_ready,
    input logic [NUM_MB*32-1:0]   mb_status,
    input logic                   overrun
);

    AST_ONE_FILL_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $countones(mb_ready & ~$past(mb_ready)) <= 1); // R10

    AST_NO_FILL_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (mb_ready & ~$past(mb_ready)) == '0); // R10

    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && rearm != '0) |=> (mb_ready & $past(rearm)) == '0); // R6

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R7

    AST_OVERRUN_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_valid)); // R7

    for (genvar m = 0; m < NUM_MB; m++) begin : g_lost
        AST_LOST_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
            mb_status[m*32+24] |-> mb_status[m*32+23]); // R4
    end

endmodule

bind can_rx_mailbox can_rx_mailbox_chk #(.NUM_MB(NUM_MB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rearm     (rearm),
    .mb_ready  (mb_ready),
    .mb_status (mb_status),
    .overrun   (overrun)
);

// File: tb/tb_can_rx_mailbox.sv
`timescale 1ns/1ps
module tb_can_rx_mailbox;

    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rx_valid = 1'b0;
    logic [28:0]    rx_id = '0;
    logic           rx_ext = 1'b0;
    logic           rx_rtr = 1'b0;
    logic [3:0]     rx_dlc = '0;
    logic [63:0]    rx_data = '0;
    logic [N*3-1:0] mb_mode;
    logic [N*29-1:0] mb_id;
    logic [N*29-1:0] mb_mask;
    logic [N-1:0]   mb_ext;
    logic [N-1:0]   rearm = '0;
    logic [N-1:0]   mb_ready;
    logic [N*32-1:0] mb_status;
    logic [N*29-1:0] mb_rx_id;
    logic [N*64-1:0] mb_rx_data;
    logic           overrun;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    can_rx_mailbox #(.NUM_MB(N)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_id(rx_id),
        .rx_ext(rx_ext), .rx_rtr(rx_rtr), .rx_dlc(rx_dlc), .rx_data(rx_data),
        .mb_mode(mb_mode), .mb_id(mb_id), .mb_mask(mb_mask), .mb_ext(mb_ext),
        .rearm(rearm), .mb_ready(mb_ready), .mb_status(mb_status),
        .mb_rx_id(mb_rx_id), .mb_rx_data(mb_rx_data), .overrun(overrun)
    );

    typedef struct {
        int          idx;
        logic [7:0]  rdy;
        logic [7:0]  lst;
        logic        ovr;
        logic [28:0] id;
        logic [3:0]  dlc;
        logic        rtr;
        logic [63:0] data;
        string       tag;
    } exp_t;

    exp_t q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: applies one frame and/or re-arm, then queues the expectation
    task automatic send(input logic v, input logic [28:0] id, input logic ext,
                        input logic rtr, input logic [3:0] dlc, input logic [63:0] data,
                        input logic [7:0] rm, input int idx, input logic [7:0] rdy,
                        input logic [7:0] lst, input logic ovr, input string tag);
        exp_t e;
        @(negedge clk);
        rx_valid = v; rx_id = id; rx_ext = ext; rx_rtr = rtr;
        rx_dlc = dlc; rx_data = data; rearm = rm;
        @(posedge clk);
        #1;
        rx_valid = 1'b0; rearm = '0;
        e.idx = idx; e.rdy = rdy; e.lst = lst; e.ovr = ovr;
        e.id = id; e.dlc = dlc; e.rtr = rtr; e.data = data; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares the ports against each queued expectation
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                logic [7:0] lost_v;
                e = q.pop_front();
                for (int m = 0; m < N; m++) lost_v[m] = mb_status[m*32+24];
                chk(mb_ready == e.rdy, e.tag, "ready", 64'(mb_ready), 64'(e.rdy));
                chk(lost_v == e.lst, e.tag, "lost", 64'(lost_v), 64'(e.lst));
                chk(overrun == e.ovr, e.tag, "overrun", 64'(overrun), 64'(e.ovr));
                if (e.idx >= 0) begin
                    logic [31:0] st_exp;
                    st_exp = (32'(e.lst[e.idx]) << 24) | (32'd1 << 23)
                           | (32'(e.rtr) << 20) | (32'(e.dlc) << 16);
                    chk(mb_rx_id[e.idx*29 +: 29] == e.id, e.tag, "id",
                        64'(mb_rx_id[e.idx*29 +: 29]), 64'(e.id));
                    chk(mb_rx_data[e.idx*64 +: 64] == e.data, e.tag, "data",
                        mb_rx_data[e.idx*64 +: 64], e.data);
                    chk(mb_status[e.idx*32 +: 32] == st_exp, e.tag, "status",
                        64'(mb_status[e.idx*32 +: 32]), 64'(st_exp));
                end
            end
        end
    end

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic logic [28:0] sid(input logic [10:0] s);
        return {s, 18'd0};
    endfunction

    initial begin
        // mailbox 0 off; 1..5 plain, any standard id; 6 exact extended id; 7 overwrite, any standard id
        for (int m = 0; m < N; m++) begin
            mb_mode[m*3 +: 3] = (m == 0) ? 3'd0 : (m == 7) ? 3'd2 : 3'd1;
            mb_id[m*29 +: 29]   = (m == 6) ? 29'h01ABCDE : 29'd0;
            mb_mask[m*29 +: 29] = (m == 6) ? 29'h1FFFFFFF : 29'd0;
            mb_ext[m] = (m == 6);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mb_ready == '0, "R9", "ready", 64'(mb_ready), 64'd0);
        chk(mb_status == '0, "R9", "status", 64'(mb_status[63:0]), 64'd0);
        chk(overrun == 1'b0, "R9", "overrun", 64'(overrun), 64'd0);

        send(1, sid(11'h100), 0, 0, 4'd8, 64'h1111, 8'h00, 1, 8'h02, 8'h00, 0, "R1_R2_first");
        send(1, sid(11'h101), 0, 0, 4'd2, 64'h2222, 8'h00, 2, 8'h06, 8'h00, 0, "R1_second");
        send(1, sid(11'h102), 0, 0, 4'd4, 64'h3333, 8'h00, 3, 8'h0E, 8'h00, 0, "R1_third");
        send(1, sid(11'h7FF), 0, 0, 4'd7, 64'h4444, 8'h00, 4, 8'h1E, 8'h00, 0, "R3_mask0");
        send(1, sid(11'h055), 0, 1, 4'd0, 64'h0, 8'h00, 5, 8'h3E, 8'h00, 0, "R5_remote");
        send(1, 29'h00ABCDE, 1, 0, 4'd3, 64'h5555, 8'h00, -1, 8'h3E, 8'h00, 1, "R3_R7_mismatch");
        send(1, 29'h01ABCDE, 1, 0, 4'd3, 64'h6666, 8'h00, 6, 8'h7E, 8'h00, 1, "R3_exact");
        send(1, sid(11'h200), 0, 0, 4'd5, 64'h7777, 8'h00, 7, 8'hFE, 8'h00, 1, "R4_free_ovwr");
        send(1, sid(11'h201), 0, 1, 4'd6, 64'h8888, 8'h00, 7, 8'hFE, 8'h80, 1, "R4_overwrite");
        send(1, 29'h01ABCDE, 1, 0, 4'd1, 64'h9999, 8'h00, -1, 8'hFE, 8'h80, 1, "R7_full_drop");
        send(0, 29'd0, 0, 0, 4'd0, 64'h0, 8'h8A, -1, 8'h74, 8'h00, 1, "R6_rearm");
        send(1, sid(11'h300), 0, 0, 4'd8, 64'hAAAA, 8'h00, 1, 8'h76, 8'h00, 1, "R1_after_rearm");
        send(1, sid(11'h301), 0, 0, 4'd8, 64'hBBBB, 8'h04, 3, 8'h7A, 8'h00, 1, "R8_same_cycle");
        send(1, sid(11'h302), 0, 0, 4'd1, 64'hCCCC, 8'h00, 2, 8'h7E, 8'h00, 1, "R8_freed_next");
        send(1, sid(11'h303), 0, 0, 4'd2, 64'hDDDD, 8'h00, 7, 8'hFE, 8'h00, 1, "R1_last");
        send(1, sid(11'h304), 0, 0, 4'd3, 64'hEEEE, 8'h00, 7, 8'hFE, 8'h80, 1, "R4_again");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule